// File: doc/BRIEF.md
# Dual-Width Arithmetic Unit with Status Flags

This block is the purely combinational arithmetic and logic stage of a small 16-bit processor datapath. It takes two 16-bit operands and a three-bit operation code and returns a result together with a byte of status bits. A single width bit chooses whether the operation runs on the full word or on the low byte only. The choice applies both to the result and to every flag derived from it.

The status byte uses a fixed layout that the processor copies straight into the low half of its flag register. A separate overflow bit goes to the upper half of that register. An active-low enable blanks the result bus so that several sources can share the writeback path. The flags stay valid while the bus is blanked. The block has no clock, no state and no handshake. All outputs follow the inputs through combinational logic only.

Top module: `dual_width_alu`

## Requirements
- R1: `wide`=1 selects 16-bit operation and `wide`=0 selects 8-bit operation. In 8-bit mode only bits 7:0 of the operands take part, and result bits 15:8 read 0 for every operation code.
- R2: Operation code 3'b000 adds the operands: result = (A + B) modulo 2^width.
- R3: Operation code 3'b001 subtracts: result = (A - B) modulo 2^width.
- R4: Operation codes 3'b010, 3'b011 and 3'b100 give bitwise AND, OR and XOR. For these codes carry, auxiliary carry and overflow are 0.
- R5: Flag bit 0 (carry) is set on a carry out of the top bit of the selected width for addition, and on a borrow into that bit for subtraction.
- R6: Flag bit 4 (auxiliary carry) is set on a carry from bit 3 into bit 4 for addition, and on a borrow from bit 4 into bit 3 for subtraction.
- R7: Flag bit 2 (parity) is 1 when result bits 7:0 hold an even number of ones. This holds in both widths.
- R8: Flag bit 6 (zero) is 1 when the result within the selected width is all zeros. Flag bit 7 (sign) equals bit 15 of the result in 16-bit mode and bit 7 in 8-bit mode.
- R9: `ovf` is 1 on two's-complement overflow of the selected width for addition or subtraction.
- R10: Flag bits 1, 3 and 5 always read 0.
- R11: While `out_en_n`=1 the result bus reads 0. The flags and `ovf` still reflect the operation.
- R12: Operation codes 3'b101 to 3'b111 pass operand A through, limited to the selected width. For these codes carry, auxiliary carry and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand (minuend for subtraction) |
| op_b | input | 16 | Second operand (subtrahend for subtraction) |
| op_code | input | 3 | Operation select |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| out_en_n | input | 1 | Active-low result enable |
| result | output | 16 | Operation result, zero when blanked |
| flags | output | 8 | Status byte: carry 0, parity 2, aux 4, zero 6, sign 7 |
| ovf | output | 1 | Signed overflow, destined for flag register bit 11 |

## Verification
Every output is due in the same cycle as the stimulus, because the path from operands to result, flags and overflow contains no register. The bench drives a new vector on each falling clock edge and samples all outputs one nanosecond later, well before the next rising edge, so the combinational paths have settled. The listed carry and overflow boundary sums are applied in both widths, next to seeded random vectors that are each run with the enable both asserted and deasserted.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned OPCODE_W = 3;

  localparam logic [OPCODE_W-1:0] OP_ADD = 3'b000;
  localparam logic [OPCODE_W-1:0] OP_SUB = 3'b001;
  localparam logic [OPCODE_W-1:0] OP_AND = 3'b010;
  localparam logic [OPCODE_W-1:0] OP_OR  = 3'b011;
  localparam logic [OPCODE_W-1:0] OP_XOR = 3'b100;

  // bit positions inside the status byte (consumed by the flag register)
  localparam int unsigned FB_CARRY = 0;
  localparam int unsigned FB_PAR   = 2;
  localparam int unsigned FB_AUX   = 4;
  localparam int unsigned FB_ZERO  = 6;
  localparam int unsigned FB_SIGN  = 7;

  typedef struct packed {
    logic carry;
    logic aux;
    logic ovf;
  } arith_st_t;
endpackage

// File: rtl/dwalu_addsub.sv
module dwalu_addsub #(
  parameter int unsigned W      = 16,
  parameter int unsigned NIB_W  = 4
) (
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  input  logic                  sub,
  input  logic                  wide,
  output logic [W-1:0]          sum,
  output dwalu_pkg::arith_st_t  st
);
  localparam int unsigned HW = W / 2;

  logic [W-1:0] b_eff;
  logic [W:0]   full;
  logic         c_nib, c_half, c_top, c_sel;
  logic         a_msb, b_msb, s_msb;

  assign b_eff = sub ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};

  // carry into bit k recovered from the sum bit: a ^ b ^ s
  assign c_nib  = a[NIB_W] ^ b_eff[NIB_W] ^ full[NIB_W];
  assign c_half = a[HW] ^ b_eff[HW] ^ full[HW];
  assign c_top  = full[W];
  assign c_sel  = wide ? c_top : c_half;

  assign a_msb = wide ? a[W-1]     : a[HW-1];
  assign b_msb = wide ? b_eff[W-1] : b_eff[HW-1];
  assign s_msb = wide ? full[W-1]  : full[HW-1];

  assign sum      = full[W-1:0];
  // for subtraction a missing carry means a borrow
  assign st.carry = c_sel ^ sub;
  assign st.aux   = c_nib ^ sub;
  assign st.ovf   = (a_msb == b_msb) && (s_msb != a_msb);
endmodule

// File: rtl/dwalu_logic.sv
module dwalu_logic #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]                     a,
  input  logic [W-1:0]                     b,
  input  logic [dwalu_pkg::OPCODE_W-1:0]   code,
  output logic [W-1:0]                     y
);
  import dwalu_pkg::*;

  always_comb begin
    unique case (code)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/dwalu_flaggen.sv
module dwalu_flaggen #(
  parameter int unsigned W     = 16,
  parameter int unsigned PAR_W = 8
) (
  input  logic [W-1:0]                   res,
  input  logic                           wide,
  input  dwalu_pkg::arith_st_t           st,
  output logic [dwalu_pkg::FLAG_W-1:0]   flags,
  output logic                           ovf
);
  import dwalu_pkg::*;
  localparam int unsigned HW = W / 2;

  logic z_full, z_half, sgn;

  assign z_full = (res == '0);
  assign z_half = (res[HW-1:0] == '0);
  assign sgn    = wide ? res[W-1] : res[HW-1];

  always_comb begin
    flags           = '0;
    flags[FB_CARRY] = st.carry;
    flags[FB_PAR]   = ~(^res[PAR_W-1:0]);
    flags[FB_AUX]   = st.aux;
    flags[FB_ZERO]  = wide ? z_full : z_half;
    flags[FB_SIGN]  = sgn;
  end

  assign ovf = st.ovf;
endmodule

// File: rtl/dual_width_alu.sv
module dual_width_alu #(
  parameter int unsigned W       = dwalu_pkg::DATA_W,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned PAR_W   = 8
) (
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic [2:0]  op_code,
  input  logic        wide,
  input  logic        out_en_n,
  output logic [15:0] result,
  output logic [7:0]  flags,
  output logic        ovf
);
  import dwalu_pkg::*;
  localparam int unsigned LANES = W / LANE_W;

  logic        is_add, is_sub, is_arith, is_logic;
  logic [W-1:0] sum, lg, raw, masked;
  arith_st_t   st_as, st_sel;

  assign is_add   = (op_code == OP_ADD);
  assign is_sub   = (op_code == OP_SUB);
  assign is_arith = is_add | is_sub;
  assign is_logic = (op_code == OP_AND) | (op_code == OP_OR) | (op_code == OP_XOR);

  dwalu_addsub #(.W(W), .NIB_W(4)) u_addsub (
    .a(op_a), .b(op_b), .sub(is_sub), .wide(wide), .sum(sum), .st(st_as)
  );

  dwalu_logic #(.W(W)) u_logic (
    .a(op_a), .b(op_b), .code(op_code), .y(lg)
  );

  assign raw = is_arith ? sum : lg;

  // lane 0 is always live, upper lanes only in wide mode
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    if (ln == 0) begin : g_low
      assign masked[LANE_W-1:0] = raw[LANE_W-1:0];
    end else begin : g_high
      assign masked[ln*LANE_W +: LANE_W] = wide ? raw[ln*LANE_W +: LANE_W] : '0;
    end
  end

  always_comb begin
    st_sel = '0;
    if (is_arith) st_sel = st_as;
  end

  dwalu_flaggen #(.W(W), .PAR_W(PAR_W)) u_flags (
    .res(masked), .wide(wide), .st(st_sel), .flags(flags), .ovf(ovf)
  );

  assign result = out_en_n ? '0 : masked;
endmodule

// File: rtl/dwalu_checker.sv
module dwalu_checker (
  input logic [15:0] op_a,
  input logic [15:0] op_b,
  input logic [2:0]  op_code,
  input logic        wide,
  input logic        out_en_n,
  input logic [15:0] result,
  input logic [7:0]  flags,
  input logic        ovf
);
  logic nonarith;
  assign nonarith = (op_code != 3'b000) && (op_code != 3'b001);

  always_comb begin
    p_blank_r11: assert (!out_en_n || result == 16'h0000)
      else $error("R11 result not blanked");
    p_narrow_upper_r1: assert (wide || out_en_n || result[15:8] == 8'h00)
      else $error("R1 upper byte live in narrow mode");
    p_zero_r8: assert (out_en_n ||
                       flags[6] == (wide ? (result == 16'h0) : (result[7:0] == 8'h0)))
      else $error("R8 zero flag mismatch");
    p_sign_r8: assert (out_en_n || flags[7] == (wide ? result[15] : result[7]))
      else $error("R8 sign flag mismatch");
    p_parity_r7: assert (out_en_n || flags[2] == ~(^result[7:0]))
      else $error("R7 parity mismatch");
    p_spare_r10: assert (flags[1] == 1'b0 && flags[3] == 1'b0 && flags[5] == 1'b0)
      else $error("R10 spare flag bit set");
    p_quiet_r4: assert (!nonarith || (!flags[0] && !flags[4] && !ovf))
      else $error("R4 carry/aux/ovf set for non-arithmetic code");
  end

  // operands only matter through the outputs above
  logic unused_ops;
  assign unused_ops = ^{op_a, op_b};
endmodule

bind dual_width_alu dwalu_checker i_dwalu_checker (
  .op_a(op_a), .op_b(op_b), .op_code(op_code), .wide(wide),
  .out_en_n(out_en_n), .result(result), .flags(flags), .ovf(ovf)
);

// File: tb/test_dual_width_alu.sv
module test_dual_width_alu;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] op_a, op_b;
  logic [2:0]  op_code;
  logic        wide, out_en_n;
  logic [15:0] result;
  logic [7:0]  flags;
  logic        ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dual_width_alu i_dual_width_alu (
    .op_a(op_a), .op_b(op_b), .op_code(op_code), .wide(wide),
    .out_en_n(out_en_n), .result(result), .flags(flags), .ovf(ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h op=%0d w=%0b oe_n=%0b)",
               tag, act, exp, op_a, op_b, op_code, wide, out_en_n);
    end
  endtask

  // reference model written from the requirements
  function automatic void model(input logic [15:0] a, input logic [15:0] b,
                                input logic [2:0] op, input logic w,
                                output int r, output int fl, output int v);
    int width, m, ua, ub, sa, sb, s, c, ax, lim;
    width = w ? 16 : 8;
    m  = (1 << width) - 1;
    ua = int'(a) & m;
    ub = int'(b) & m;
    sa = (ua >= (1 << (width-1))) ? ua - (1 << width) : ua;
    sb = (ub >= (1 << (width-1))) ? ub - (1 << width) : ub;
    lim = 1 << (width-1);
    c = 0; ax = 0; v = 0;
    case (op)
      3'd0: begin
        r = (ua + ub) & m; c = ((ua + ub) > m) ? 1 : 0;
        ax = (((ua & 15) + (ub & 15)) > 15) ? 1 : 0;
        s = sa + sb; v = (s >= lim || s < -lim) ? 1 : 0;
      end
      3'd1: begin
        r = (ua - ub) & m; c = (ua < ub) ? 1 : 0;
        ax = ((ua & 15) < (ub & 15)) ? 1 : 0;
        s = sa - sb; v = (s >= lim || s < -lim) ? 1 : 0;
      end
      3'd2: r = ua & ub;
      3'd3: r = ua | ub;
      3'd4: r = ua ^ ub;
      default: r = ua;
    endcase
    fl = c | (($countones(r & 255) % 2 == 0) ? 4 : 0) | (ax << 4)
         | ((r == 0) ? 64 : 0) | (((r >> (width-1)) & 1) << 7);
  endfunction

  task automatic apply(input logic [15:0] a, input logic [15:0] b,
                       input logic [2:0] op, input logic w, input logic oe_n);
    int er, ef, ev;
    string rtag;
    @(negedge clk);
    op_a = a; op_b = b; op_code = op; wide = w; out_en_n = oe_n;
    #1;
    model(a, b, op, w, er, ef, ev);
    case (op)
      3'd0: rtag = "R2 add result";
      3'd1: rtag = "R3 sub result";
      3'd2, 3'd3, 3'd4: rtag = "R4 logic result";
      default: rtag = "R12 pass result";
    endcase
    if (oe_n) chk("R11 blanked result", int'(result), 0);
    else begin
      chk(rtag, int'(result), er);
      if (!w) chk("R1 upper byte", int'(result[15:8]), 0);
    end
    chk("R5 carry", int'(flags[0]), ef & 1);
    chk("R7 parity", int'(flags[2]), (ef >> 2) & 1);
    chk("R6 aux", int'(flags[4]), (ef >> 4) & 1);
    chk("R8 zero", int'(flags[6]), (ef >> 6) & 1);
    chk("R8 sign", int'(flags[7]), (ef >> 7) & 1);
    chk("R10 spare", int'({flags[5], flags[3], flags[1]}), 0);
    chk("R9 overflow", int'(ovf), ev);
  endtask

  initial begin
    #150000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    op_a = '0; op_b = '0; op_code = '0; wide = 1'b1; out_en_n = 1'b0;
    #1;
    // idle state: 0+0 in 16-bit mode
    chk("R2 idle result", int'(result), 0);
    chk("R8 idle zero", int'(flags[6]), 1);
    chk("R7 idle parity", int'(flags[2]), 1);

    // directed boundary sums, with hard-coded outputs
    apply(16'h007F, 16'h0001, 3'd0, 1'b0, 1'b0);
    chk("R9 7F+1 byte ovf", int'(ovf), 1);
    chk("R2 7F+1 byte flags", int'(flags), 8'h90);
    apply(16'h00FF, 16'h0001, 3'd0, 1'b0, 1'b0);
    chk("R5 FF+1 byte flags", int'(flags), 8'h55);
    apply(16'h7FFF, 16'h0001, 3'd0, 1'b1, 1'b0);
    chk("R9 7FFF+1 word result", int'(result), 16'h8000);
    chk("R9 7FFF+1 word flags", int'(flags), 8'h94);
    apply(16'hFFFF, 16'h0001, 3'd0, 1'b1, 1'b0);
    chk("R5 FFFF+1 word flags", int'(flags), 8'h55);
    apply(16'h0000, 16'h0001, 3'd1, 1'b1, 1'b0);
    chk("R3 0-1 word result", int'(result), 16'hFFFF);
    chk("R5 0-1 word flags", int'(flags), 8'h95);
    apply(16'h0000, 16'h0001, 3'd1, 1'b0, 1'b0);
    chk("R3 0-1 byte result", int'(result), 16'h00FF);
    apply(16'h8000, 16'h0001, 3'd1, 1'b1, 1'b0);
    apply(16'h1280, 16'h3401, 3'd1, 1'b0, 1'b0);
    apply(16'hABCD, 16'h1234, 3'd5, 1'b1, 1'b0);
    apply(16'hABCD, 16'h1234, 3'd7, 1'b0, 1'b0);
    apply(16'hF0F0, 16'hFF00, 3'd2, 1'b1, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ra, rb;
      logic [2:0]  ro;
      ra = 16'($urandom);
      rb = 16'($urandom);
      ro = ($urandom_range(0, 3) != 0) ? 3'($urandom_range(0, 1)) : 3'($urandom);
      apply(ra, rb, ro, 1'($urandom), 1'b0);
      apply(ra, rb, ro, 1'($urandom), 1'b1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule